// File: doc/BRIEF.md
# External Bus Read Sequencer

This block performs reads on an external parallel bus that has separate chip-select and strobe lines. An internal client raises a request with a 19-bit address while the block is idle. The block then runs the external read in three timed phases. In the lead phase, chip select is asserted and the address is placed on the bus. In the active phase, the read strobe is low. In the trail phase, the strobe is released but chip select is still held. The client then receives the 16-bit word with a one-cycle done pulse. Each phase length is a count of timing-clock cycles. The lead, active and trail counts come from configuration inputs. A doubling option multiplies every count by two.

The block also drives an output bus clock. This clock runs either at the timing-clock rate or at half that rate. Every access must begin on a rising edge of the bus clock. In half-rate mode, a request that arrives on the wrong phase gets one idle alignment cycle before lead begins. A synchronous ready input can optionally lengthen the active phase, one cycle for each low sample. Between accesses the address bus keeps its last value. The write strobe and the read/write indicator are held in their read levels at all times.

Top module: `xbus_rd_seq`

## Requirements
- R1: While reset is asserted (rst_n low): bus_cs_n, bus_rd_n, bus_we_n and bus_rnw are 1; busy and rd_done are 0; bus_addr and rd_data are 0.
- R2: A request (req_valid high) seen at a clock edge while idle is accepted at that edge. busy is then 1 in every following cycle up to the trail's last cycle and is 0 in the rd_done cycle. A request held high during an access is not taken (bus_addr does not change) and is accepted at the edge after rd_done.
- R3: Lead lasts L cycles, where L is cfg_lead, or 2*cfg_lead when cfg_x2 is 1. During lead, bus_cs_n is 0, bus_rd_n is 1 and bus_addr equals the requested address.
- R4: With cfg_use_rdy at 0, active lasts exactly A cycles (cfg_active, or twice that with cfg_x2), with bus_rd_n and bus_cs_n both 0, whatever bus_rdy does.
- R5: With cfg_use_rdy at 1, bus_rdy is first sampled at the edge that ends active cycle A. Each low sample adds one active cycle and is followed by a new sample at the end of that cycle. The phase ends at the first high sample.
- R6: After bus_rd_n rises, bus_cs_n stays 0 for T cycles (cfg_trail, or twice that with cfg_x2). rd_done is then 1 for exactly one cycle, with bus_cs_n back at 1.
- R7: rd_data takes the value of bus_din present at the edge ending the last active cycle. It is valid when rd_done is 1 and is held until the next read captures new data.
- R8: With cfg_half_clk at 0, bus_clk equals clk. With cfg_half_clk at 1, bus_clk changes level on every clk rising edge.
- R9: In half-rate mode, lead always begins at a clk edge where bus_clk rises. If bus_clk is 1 when the request is accepted, one alignment cycle comes first. During that cycle bus_cs_n, bus_rd_n and bus_we_n are 1, busy is 1, and bus_addr keeps the previous address.
- R10: bus_addr changes only at the edge that starts a lead phase. It keeps that value through the access and while idle.
- R11: The lead, active, trail, ready-use and doubling settings are latched when the request is accepted. Changing them during the access has no effect on it. cfg_half_clk is static and may only change while idle.
- R12: bus_we_n and bus_rnw are 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request |
| req_addr | input | 19 | Read address |
| busy | output | 1 | Access in progress; requests are not taken |
| rd_data | output | 16 | Captured read word |
| rd_done | output | 1 | One-cycle completion pulse |
| cfg_lead | input | 4 | Lead phase count |
| cfg_active | input | 4 | Active phase count (at least 3 when ready is used) |
| cfg_trail | input | 4 | Trail phase count |
| cfg_use_rdy | input | 1 | Enable synchronous ready stretching |
| cfg_x2 | input | 1 | Double all phase counts |
| cfg_half_clk | input | 1 | Bus clock at half the timing rate |
| bus_clk | output | 1 | External bus clock |
| bus_cs_n | output | 1 | Zone chip select, active low |
| bus_addr | output | 19 | External address, held between accesses |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, always inactive |
| bus_rnw | output | 1 | Read/write indicator, always read (1) |
| bus_din | input | 16 | External data bus |
| bus_rdy | input | 1 | Synchronous ready |

## Verification
Accesses are run with minimum and maximum phase counts, with doubling on and off, and with ready disabled or held low for zero to five samples. The cycle count of each phase therefore separates a wrong count, a missing doubling and a wrong ready sample point. Data is only correct on the last active cycle, so a capture one edge early or late shows up as the inverted word. Each half-rate access runs once from each bus-clock phase, which separates the aligned start from the direct one. Scrambling the configuration inputs right after acceptance exposes any path that does not use the latched settings.

// File: rtl/xbus_pkg.sv
`timescale 1ns/1ps
package xbus_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALIGN,
      ST_LEAD,
      ST_ACTIVE,
      ST_TRAIL
   } xrd_state_t;

endpackage

// File: rtl/xbus_clkgen.sv
`timescale 1ns/1ps
// Output bus clock source: full rate, or divided by two when selected.
// rise_next tells whether the coming clk edge is a rising bus_clk edge.
module xbus_clkgen #(
   parameter bit HALF_EN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic half_sel,
   output logic bus_clk,
   output logic rise_next
);

   generate
      if (HALF_EN) begin : g_div
         logic div_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) div_q <= 1'b0;
            else        div_q <= ~div_q;
         end

         assign bus_clk   = half_sel ? div_q : clk;
         assign rise_next = half_sel ? ~div_q : 1'b1;
      end else begin : g_full
         logic unused_in;
         assign unused_in = half_sel ^ rst_n;
         assign bus_clk   = clk;
         assign rise_next = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/xbus_phase_tmr.sv
`timescale 1ns/1ps
// Down counter for phase lengths: loads length-1, counts to zero, rests there.
module xbus_phase_tmr #(
   parameter int LEN_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             run,
   output logic             zero
);

   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (load)                cnt_q <= load_val;
      else if (run && cnt_q != '0)  cnt_q <= cnt_q - {{(LEN_W-1){1'b0}}, 1'b1};
   end

   assign zero = (cnt_q == '0);

endmodule

// File: rtl/xbus_rd_dpath.sv
`timescale 1ns/1ps
// Address latch, held bus address and read-data capture.
module xbus_rd_dpath #(
   parameter int ADDR_W = 19,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              lat_en,
   input  logic              drive_en,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              cap_en,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] rd_data
);

   logic [ADDR_W-1:0] pend_addr_q;
   logic [ADDR_W-1:0] out_addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_addr_q <= '0;
      else if (lat_en) pend_addr_q <= req_addr;
   end

   // the bus address moves only when a lead phase begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_addr_q <= '0;
      else if (drive_en) out_addr_q <= lat_en ? req_addr : pend_addr_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      data_q <= '0;
      else if (cap_en) data_q <= bus_din;
   end

   assign bus_addr = out_addr_q;
   assign rd_data  = data_q;

endmodule

// File: rtl/xbus_rd_seq.sv
`timescale 1ns/1ps
module xbus_rd_seq
   import xbus_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 4,
   parameter bit HALF_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              busy,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_done,
   input  logic [CNT_W-1:0]  cfg_lead,
   input  logic [CNT_W-1:0]  cfg_active,
   input  logic [CNT_W-1:0]  cfg_trail,
   input  logic              cfg_use_rdy,
   input  logic              cfg_x2,
   input  logic              cfg_half_clk,
   output logic              bus_clk,
   output logic              bus_cs_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_rd_n,
   output logic              bus_we_n,
   output logic              bus_rnw,
   input  logic [DATA_W-1:0] bus_din,
   input  logic              bus_rdy
);

   localparam int LEN_W = CNT_W + 1;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("xbus_rd_seq: ADDR_W must be at least 1");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("xbus_rd_seq: DATA_W must be at least 1");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("xbus_rd_seq: CNT_W must be at least 2");
      end
   endgenerate

   // effective phase length minus one, doubled on request
   function automatic logic [LEN_W-1:0] len_m1(input logic [CNT_W-1:0] n, input logic dbl);
      logic [LEN_W-1:0] eff;
      eff = dbl ? {n, 1'b0} : {1'b0, n};
      return eff - {{(LEN_W-1){1'b0}}, 1'b1};
   endfunction

   xrd_state_t state_q, state_d;

   logic [CNT_W-1:0] lat_lead_q, lat_act_q, lat_trail_q;
   logic             lat_use_q, lat_x2_q;
   logic             rise_next;
   logic             tmr_zero, tmr_load;
   logic [LEN_W-1:0] tmr_val, lead_val;
   logic             accept, cap_en, drive_en, done_q;

   xbus_clkgen #(.HALF_EN(HALF_EN)) u_clk (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_sel  (cfg_half_clk),
      .bus_clk   (bus_clk),
      .rise_next (rise_next)
   );

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:   if (req_valid) state_d = rise_next ? ST_LEAD : ST_ALIGN;
         ST_ALIGN:  state_d = ST_LEAD;
         ST_LEAD:   if (tmr_zero) state_d = ST_ACTIVE;
         ST_ACTIVE: if (tmr_zero && (!lat_use_q || bus_rdy)) state_d = ST_TRAIL;
         ST_TRAIL:  if (tmr_zero) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_lead_q  <= '0;
         lat_act_q   <= '0;
         lat_trail_q <= '0;
         lat_use_q   <= 1'b0;
         lat_x2_q    <= 1'b0;
      end else if (accept) begin
         lat_lead_q  <= cfg_lead;
         lat_act_q   <= cfg_active;
         lat_trail_q <= cfg_trail;
         lat_use_q   <= cfg_use_rdy;
         lat_x2_q    <= cfg_x2;
      end
   end

   // lead starts either at acceptance (live settings) or after alignment (latched)
   assign lead_val = (state_q == ST_IDLE) ? len_m1(cfg_lead, cfg_x2) : len_m1(lat_lead_q, lat_x2_q);

   always_comb begin
      case (state_d)
         ST_LEAD:   tmr_val = lead_val;
         ST_ACTIVE: tmr_val = len_m1(lat_act_q, lat_x2_q);
         default:   tmr_val = len_m1(lat_trail_q, lat_x2_q);
      endcase
   end

   assign tmr_load = (state_d != state_q) &&
                     (state_d == ST_LEAD || state_d == ST_ACTIVE || state_d == ST_TRAIL);

   xbus_phase_tmr #(.LEN_W(LEN_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .run      (busy),
      .zero     (tmr_zero)
   );

   assign drive_en = (state_d == ST_LEAD) && (state_q != ST_LEAD);
   assign cap_en   = (state_q == ST_ACTIVE) && (state_d == ST_TRAIL);

   xbus_rd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_addr (req_addr),
      .lat_en   (accept),
      .drive_en (drive_en),
      .bus_din  (bus_din),
      .cap_en   (cap_en),
      .bus_addr (bus_addr),
      .rd_data  (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= (state_q == ST_TRAIL) && (state_d == ST_IDLE);
   end

   assign rd_done  = done_q;
   assign busy     = (state_q != ST_IDLE);
   assign bus_cs_n = !(state_q == ST_LEAD || state_q == ST_ACTIVE || state_q == ST_TRAIL);
   assign bus_rd_n = (state_q != ST_ACTIVE);
   assign bus_we_n = 1'b1;
   assign bus_rnw  = 1'b1;

endmodule

// File: rtl/xbus_rd_seq_chk.sv
`timescale 1ns/1ps
module xbus_rd_seq_chk #(
   parameter int ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              rd_done,
   input logic              cfg_half_clk,
   input logic              bus_clk,
   input logic              bus_cs_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_rd_n,
   input logic              bus_we_n,
   input logic              bus_rnw
);

   // R4
   rd_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_n |-> !bus_cs_n);

   // R3
   rd_after_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_rd_n) |-> $past(!bus_cs_n));

   // R12
   wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we_n && bus_rnw);

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);

   // R6
   trail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd_n) |-> !bus_cs_n);

   // R2
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !busy);

   // R10
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(bus_cs_n) |-> $stable(bus_addr));

   // R9
   lead_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(bus_cs_n) && cfg_half_clk) |-> bus_clk);

endmodule

bind xbus_rd_seq xbus_rd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .rd_done      (rd_done),
   .cfg_half_clk (cfg_half_clk),
   .bus_clk      (bus_clk),
   .bus_cs_n     (bus_cs_n),
   .bus_addr     (bus_addr),
   .bus_rd_n     (bus_rd_n),
   .bus_we_n     (bus_we_n),
   .bus_rnw      (bus_rnw)
);

// File: tb/sim_xbus_rd_seq.sv
`timescale 1ns/1ps
module sim_xbus_rd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [18:0] req_addr = '0;
   logic        busy, rd_done;
   logic [15:0] rd_data;
   logic [3:0]  cfg_lead = 4'd1, cfg_active = 4'd3, cfg_trail = 4'd1;
   logic        cfg_use_rdy = 1'b0, cfg_x2 = 1'b0, cfg_half_clk = 1'b0;
   logic        bus_clk, bus_cs_n, bus_rd_n, bus_we_n, bus_rnw;
   logic [18:0] bus_addr;
   logic [15:0] bus_din = '0;
   logic        bus_rdy = 1'b0;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   xbus_rd_seq u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .busy(busy), .rd_data(rd_data), .rd_done(rd_done),
      .cfg_lead(cfg_lead), .cfg_active(cfg_active), .cfg_trail(cfg_trail),
      .cfg_use_rdy(cfg_use_rdy), .cfg_x2(cfg_x2), .cfg_half_clk(cfg_half_clk),
      .bus_clk(bus_clk), .bus_cs_n(bus_cs_n), .bus_addr(bus_addr),
      .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_rnw(bus_rnw),
      .bus_din(bus_din), .bus_rdy(bus_rdy)
   );

   typedef struct packed {
      logic [18:0] addr;
      logic [3:0]  lead;
      logic [3:0]  act;
      logic [3:0]  trail;
      logic        use_rdy;
      logic        x2;
      logic        half;
      logic [3:0]  wait_n;
      logic [15:0] data;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{19'h12345, 4'd1,  4'd3,  4'd1,  1'b0, 1'b0, 1'b0, 4'd0, 16'hA5C3},
      '{19'h7FFFF, 4'd2,  4'd4,  4'd3,  1'b1, 1'b0, 1'b0, 4'd2, 16'h0F0F},
      '{19'h00001, 4'd1,  4'd3,  4'd1,  1'b1, 1'b1, 1'b1, 4'd0, 16'hFFFF},
      '{19'h55555, 4'd3,  4'd5,  4'd2,  1'b0, 1'b1, 1'b1, 4'd3, 16'h1234},
      '{19'h2AAAA, 4'd15, 4'd15, 4'd15, 1'b1, 1'b1, 1'b0, 4'd5, 16'h8001},
      '{19'h00000, 4'd1,  4'd3,  4'd1,  1'b1, 1'b0, 1'b1, 4'd1, 16'h0000}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input vec_t v, input logic want_clk);
      int eff_ld, eff_ac, eff_tr, exp_ac, n_al, n_ld, n_ac, n_tr, ph;
      logic [18:0] prev_addr;
      logic pre_clk, lead_clk, got_done;
      eff_ld = v.x2 ? 2 * int'(v.lead)  : int'(v.lead);
      eff_ac = v.x2 ? 2 * int'(v.act)   : int'(v.act);
      eff_tr = v.x2 ? 2 * int'(v.trail) : int'(v.trail);
      exp_ac = v.use_rdy ? eff_ac + int'(v.wait_n) : eff_ac;
      @(negedge clk);
      while (busy) @(negedge clk);
      cfg_half_clk = v.half;
      @(negedge clk);
      if (v.half && bus_clk !== want_clk) @(negedge clk);
      prev_addr = bus_addr;
      pre_clk   = bus_clk;
      req_valid = 1'b1; req_addr = v.addr;
      cfg_lead = v.lead; cfg_active = v.act; cfg_trail = v.trail;
      cfg_use_rdy = v.use_rdy; cfg_x2 = v.x2;
      bus_rdy = 1'b0; bus_din = ~v.data;
      @(negedge clk);
      req_valid = 1'b0;
      // R11: scramble settings after acceptance
      cfg_lead = ~v.lead; cfg_active = ~v.act; cfg_trail = ~v.trail;
      cfg_use_rdy = ~v.use_rdy; cfg_x2 = ~v.x2;
      n_al = 0; n_ld = 0; n_ac = 0; n_tr = 0; ph = 0;
      lead_clk = 1'b1; got_done = 1'b0;
      for (int g = 0; g < 500; g++) begin
         if (rd_done) begin got_done = 1'b1; break; end
         bus_rdy = 1'b0; bus_din = ~v.data;
         if (bus_cs_n) begin
            n_al++;
            chk("R9 align strobes", 32'({bus_rd_n, bus_we_n}), 32'h3);
            chk("R9 align address held", 32'(bus_addr), 32'(prev_addr));
            chk("R2 busy during align", 32'(busy), 32'h1);
         end else if (!bus_rd_n) begin
            n_ac++; ph = 2;
            bus_rdy = (n_ac >= eff_ac + int'(v.wait_n));
            if (n_ac == exp_ac) bus_din = v.data;
         end else if (ph < 2) begin
            if (n_ld == 0) begin
               lead_clk = bus_clk;
               chk("R3 lead address", 32'(bus_addr), 32'(v.addr));
            end
            n_ld++; ph = 1;
         end else begin
            n_tr++;
         end
         @(negedge clk);
      end
      chk("R2 watchdog done seen", 32'(got_done), 32'h1);
      chk("R9 alignment cycles", 32'(n_al), (v.half && pre_clk) ? 32'd1 : 32'd0);
      if (v.half) chk("R9 R8 lead on bus_clk rise", 32'(lead_clk), 32'h1);
      chk("R3 R11 lead cycles", 32'(n_ld), 32'(eff_ld));
      chk(v.use_rdy ? "R5 R11 active cycles with ready" : "R4 R11 active cycles",
          32'(n_ac), 32'(exp_ac));
      chk("R6 R11 trail cycles", 32'(n_tr), 32'(eff_tr));
      chk("R7 read data", 32'(rd_data), 32'(v.data));
      chk("R6 cs released at done", 32'(bus_cs_n), 32'h1);
      chk("R2 idle at done", 32'(busy), 32'h0);
      chk("R12 write strobe and rnw", 32'({bus_we_n, bus_rnw}), 32'h3);
      @(negedge clk);
      chk("R6 done one cycle", 32'(rd_done), 32'h0);
      chk("R7 data held", 32'(rd_data), 32'(v.data));
      chk("R10 address held idle", 32'(bus_addr), 32'(v.addr));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int bad_busy, addr_moved;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk("R1 strobes in reset", 32'({bus_cs_n, bus_rd_n, bus_we_n, bus_rnw}), 32'hF);
      chk("R1 busy/done in reset", 32'({busy, rd_done}), 32'h0);
      chk("R1 addr in reset", 32'(bus_addr), 32'h0);
      chk("R1 data in reset", 32'(rd_data), 32'h0);
      rst_n = 1'b1;

      // R8 clock rate
      cfg_half_clk = 1'b0;
      @(negedge clk);
      chk("R8 full rate low", 32'(bus_clk), 32'h0);
      @(posedge clk); #1;
      chk("R8 full rate high", 32'(bus_clk), 32'h1);
      cfg_half_clk = 1'b1;
      @(negedge clk);
      begin
         logic last;
         int toggles;
         last = bus_clk; toggles = 0;
         for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (bus_clk !== last) toggles++;
            last = bus_clk;
         end
         chk("R8 half rate toggles", 32'(toggles), 32'd8);
      end

      // table walk, each half-rate vector from both bus_clk phases
      for (int pass = 0; pass < 2; pass++)
         for (int i = 0; i < 6; i++)
            run_vec(VECS[i], pass[0]);

      // R2 request held during an access
      cfg_half_clk = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_addr = 19'h0ABCD;
      cfg_lead = 4'd1; cfg_active = 4'd3; cfg_trail = 4'd1;
      cfg_use_rdy = 1'b0; cfg_x2 = 1'b0;
      @(negedge clk);
      req_addr = 19'h4321F;
      bad_busy = 0; addr_moved = 0;
      for (int g = 0; g < 50 && !rd_done; g++) begin
         if (!busy) bad_busy++;
         if (bus_addr !== 19'h0ABCD) addr_moved++;
         @(negedge clk);
      end
      chk("R2 busy through access", 32'(bad_busy), 32'd0);
      chk("R2 held request not taken", 32'(addr_moved), 32'd0);
      chk("R2 idle on done", 32'({rd_done, busy}), 32'h2);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 held request taken after done", 32'(bus_addr), 32'h4321F);
      chk("R2 lead after held request", 32'(bus_cs_n), 32'h0);
      for (int g = 0; g < 50 && !rd_done; g++) @(negedge clk);
      chk("R2 second access done", 32'(rd_done), 32'h1);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule